// File: doc/BRIEF.md
# Masked GPIO Port Register Block

This block controls one general-purpose I/O port. A bus master programs it over a simple single-cycle register bus. Each pin has a direction bit and an output latch bit. Input levels from the pads pass through a two-flop synchronizer before software can read them. Any register can be written as a whole word, as either half-word or as any single byte, using four byte-lane strobes.

The output latch can be changed in three ways:
- a direct load through the pin-value register;
- a set register, which raises bits written with 1;
- a clear register, which lowers bits written with 1.

A per-bit mask register filters all three kinds of write. The same mask blanks the masked bits when the pin-value register is read. The pad sees the latch only on pins whose direction bit selects output.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, mask and output latch are all 0, every readable register returns 0, and `padOe` and `padOut` are 0.
- R2: Word index 0 is the direction register. A bit of 1 makes that pin an output (`padOe` bit 1) and a bit of 0 makes it an input. It is read back unchanged and changes only on a write to index 0.
- R3: Writing word index 3 (set) raises every latch bit written with 1. Bits written with 0 keep their value.
- R4: Writing word index 4 (clear) lowers every latch bit written with 1. Bits written with 0 keep their value. Index 4 always reads 0.
- R5: Writing word index 2 (pin value) loads the written data straight into the output latch.
- R6: Reading word index 2 returns the pad input level, whatever the pin's direction. A pad change becomes visible two rising clock edges after it occurs.
- R7: Reading word index 3 returns the current output latch.
- R8: Word index 1 is the mask register. A mask bit of 1 stops writes through indexes 2, 3 and 4 from changing that latch bit.
- R9: A masked bit reads 0 from word index 2.
- R10: Byte strobe k (bit k of `busBe`) enables data bits 8k+7..8k on a write. Lanes whose strobe is 0 keep their value. A write with no strobe set changes nothing.
- R11: `padOut` carries the latch only where the direction bit is 1 and is 0 on input pins. Setting or clearing an input pin therefore leaves the pad unchanged.
- R12: Word indexes 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Word index of the register accessed |
| busWdata | input | PORT_W | Write data |
| busBe | input | PORT_W/8 | Byte-lane strobes for writes |
| busWe | input | 1 | Write enable, sampled on the rising edge |
| busRdata | output | PORT_W | Read data for `busAddr`, combinational |
| padIn | input | PORT_W | Pad input levels, asynchronous |
| padOut | output | PORT_W | Output level per pin |
| padOe | output | PORT_W | Output enable per pin |

## Verification
The bench builds the block with its defaults: a 32-bit port, a 3-bit word index and two synchronizer stages. With these values there are four byte lanes, so single-byte and half-word writes can be mixed with masked bits. The three unmapped indexes 5 to 7 can be reached. The two-edge input latency can be counted edge by edge at the pin-value read-back.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Word index of each register. The bench relies on these values.
  localparam int unsigned IDX_DIR  = 0;
  localparam int unsigned IDX_MASK = 1;
  localparam int unsigned IDX_PIN  = 2;
  localparam int unsigned IDX_SET  = 3;
  localparam int unsigned IDX_CLR  = 4;

  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_MASK = 3'd1,
    SEL_PIN  = 3'd2,
    SEL_SET  = 3'd3,
    SEL_CLR  = 3'd4,
    SEL_NONE = 3'd7
  } regSel_e;

  // Strobes passed from the decoder to the datapath.
  typedef struct packed {
    logic    wrDir;
    logic    wrMask;
    logic    wrPin;
    logic    wrSet;
    logic    wrClr;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned PORT_W = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] din,
  output logic [PORT_W-1:0] dout
);

  localparam int unsigned LAST = SYNC_N - 1;

  logic [PORT_W-1:0] stages [SYNC_N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_N; i++) stages[i] <= '0;
    end else begin
      stages[0] <= din;
      for (int i = 1; i < SYNC_N; i++) stages[i] <= stages[i-1];
    end
  end

  assign dout = stages[LAST];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned BYTE_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BYTE_N-1:0] busBe,
  output ctrlStrobes_t      strb
);

  regSel_e sel;
  logic    wrAny;

  always_comb begin
    if      (busAddr == ADDR_W'(IDX_DIR))  sel = SEL_DIR;
    else if (busAddr == ADDR_W'(IDX_MASK)) sel = SEL_MASK;
    else if (busAddr == ADDR_W'(IDX_PIN))  sel = SEL_PIN;
    else if (busAddr == ADDR_W'(IDX_SET))  sel = SEL_SET;
    else if (busAddr == ADDR_W'(IDX_CLR))  sel = SEL_CLR;
    else                                   sel = SEL_NONE;
  end

  assign wrAny = busWe & (|busBe);

  always_comb begin
    strb.wrDir  = wrAny & (sel == SEL_DIR);
    strb.wrMask = wrAny & (sel == SEL_MASK);
    strb.wrPin  = wrAny & (sel == SEL_PIN);
    strb.wrSet  = wrAny & (sel == SEL_SET);
    strb.wrClr  = wrAny & (sel == SEL_CLR);
    strb.rdSel  = sel;
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDir, strb.wrMask, strb.wrPin, strb.wrSet, strb.wrClr})); // R12
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> !(strb.wrDir | strb.wrMask | strb.wrPin | strb.wrSet | strb.wrClr)); // R10
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr > ADDR_W'(IDX_CLR)) |-> !(strb.wrDir | strb.wrMask | strb.wrPin | strb.wrSet | strb.wrClr)); // R12

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strb,
  input  logic [PORT_W-1:0]     busWdata,
  input  logic [PORT_W/8-1:0]   busBe,
  input  logic [PORT_W-1:0]     padIn,
  output logic [PORT_W-1:0]     busRdata,
  output logic [PORT_W-1:0]     padOut,
  output logic [PORT_W-1:0]     padOe
);

  localparam int unsigned BYTE_N = PORT_W / 8;

  logic [PORT_W-1:0] dirReg;
  logic [PORT_W-1:0] maskReg;
  logic [PORT_W-1:0] outLatch;
  logic [PORT_W-1:0] laneMask;
  logic [PORT_W-1:0] effMask;
  logic [PORT_W-1:0] pinSync;

  for (genvar b = 0; b < BYTE_N; b++) begin : g_lane
    assign laneMask[b*8 +: 8] = {8{busBe[b]}};
  end

  assign effMask = laneMask & ~maskReg;

  gpio_port_sync #(.PORT_W(PORT_W), .SYNC_N(SYNC_N)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (padIn),
    .dout (pinSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg   <= '0;
      maskReg  <= '0;
      outLatch <= '0;
    end else begin
      if (strb.wrDir)  dirReg  <= (dirReg  & ~laneMask) | (busWdata & laneMask);
      if (strb.wrMask) maskReg <= (maskReg & ~laneMask) | (busWdata & laneMask);
      if (strb.wrPin)      outLatch <= (outLatch & ~effMask) | (busWdata & effMask);
      else if (strb.wrSet) outLatch <= outLatch | (busWdata & effMask);
      else if (strb.wrClr) outLatch <= outLatch & ~(busWdata & effMask);
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_DIR:  busRdata = dirReg;
      SEL_MASK: busRdata = maskReg;
      SEL_PIN:  busRdata = pinSync & ~maskReg;
      SEL_SET:  busRdata = outLatch;
      default:  busRdata = '0;
    endcase
  end

  assign padOe  = dirReg;
  assign padOut = outLatch & dirReg;

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((outLatch ^ $past(outLatch)) & $past(maskReg)) == '0)); // R8
  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet |=> (($past(outLatch) & ~outLatch) == '0)); // R3
  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((outLatch & ~$past(outLatch)) == '0)); // R4
  AST_DIR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirReg)); // R2

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [PORT_W-1:0]   busWdata,
  input  logic [PORT_W/8-1:0] busBe,
  input  logic                busWe,
  output logic [PORT_W-1:0]   busRdata,
  input  logic [PORT_W-1:0]   padIn,
  output logic [PORT_W-1:0]   padOut,
  output logic [PORT_W-1:0]   padOe
);

  localparam int unsigned BYTE_N = PORT_W / 8;

  ctrlStrobes_t strb;

  gpio_port_ctrl #(.ADDR_W(ADDR_W), .BYTE_N(BYTE_N)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busBe   (busBe),
    .strb    (strb)
  );

  gpio_port_dp #(.PORT_W(PORT_W), .SYNC_N(SYNC_N)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .busBe    (busBe),
    .padIn    (padIn),
    .busRdata (busRdata),
    .padOut   (padOut),
    .padOe    (padOe)
  );

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

  localparam int CLK_P = 10;
  localparam logic [31:0] PADV = 32'hA5A5_0F0F;

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 4'hF, 32'h0,          32'h0,          8'd1 },  // R1 dir reads 0
    '{1'b1, 3'd0, 4'hF, 32'hFFFF_0000,  32'h0,          8'd2 },  // R2 write dir
    '{1'b0, 3'd0, 4'hF, 32'h0,          32'hFFFF_0000,  8'd2 },  // R2
    '{1'b1, 3'd3, 4'hF, 32'h0000_00FF,  32'h0,          8'd3 },  // R3 set
    '{1'b0, 3'd3, 4'hF, 32'h0,          32'h0000_00FF,  8'd7 },  // R7
    '{1'b1, 3'd3, 4'hF, 32'h0,          32'h0,          8'd3 },  // R3 zeros no effect
    '{1'b0, 3'd3, 4'hF, 32'h0,          32'h0000_00FF,  8'd3 },  // R3
    '{1'b1, 3'd4, 4'hF, 32'h0000_000F,  32'h0,          8'd4 },  // R4 clear
    '{1'b0, 3'd3, 4'hF, 32'h0,          32'h0000_00F0,  8'd4 },  // R4
    '{1'b0, 3'd4, 4'hF, 32'h0,          32'h0,          8'd4 },  // R4 clear reads 0
    '{1'b1, 3'd2, 4'hF, 32'h1234_5678,  32'h0,          8'd5 },  // R5 direct load
    '{1'b0, 3'd3, 4'hF, 32'h0,          32'h1234_5678,  8'd5 },  // R5
    '{1'b1, 3'd2, 4'h1, 32'hAABB_CCDD,  32'h0,          8'd10},  // R10 byte 0
    '{1'b0, 3'd3, 4'hF, 32'h0,          32'h1234_56DD,  8'd10},  // R10
    '{1'b1, 3'd2, 4'hC, 32'h0,          32'h0,          8'd10},  // R10 upper half
    '{1'b0, 3'd3, 4'hF, 32'h0,          32'h0000_56DD,  8'd10},  // R10
    '{1'b1, 3'd1, 4'hF, 32'h0000_FFFF,  32'h0,          8'd8 },  // R8 mask low half
    '{1'b0, 3'd1, 4'hF, 32'h0,          32'h0000_FFFF,  8'd8 },  // R8
    '{1'b1, 3'd2, 4'hF, 32'hFFFF_FFFF,  32'h0,          8'd8 },  // R8 masked load
    '{1'b0, 3'd3, 4'hF, 32'h0,          32'hFFFF_56DD,  8'd8 },  // R8
    '{1'b1, 3'd4, 4'hF, 32'hFFFF_FFFF,  32'h0,          8'd8 },  // R8 masked clear
    '{1'b0, 3'd3, 4'hF, 32'h0,          32'h0000_56DD,  8'd8 },  // R8
    '{1'b0, 3'd2, 4'hF, 32'h0,          32'hA5A5_0000,  8'd9 },  // R9 masked read
    '{1'b1, 3'd1, 4'hF, 32'h0,          32'h0,          8'd9 },  // R9 unmask
    '{1'b0, 3'd2, 4'hF, 32'h0,          32'hA5A5_0F0F,  8'd6 },  // R6 pin read
    '{1'b1, 3'd5, 4'hF, 32'hFFFF_FFFF,  32'h0,          8'd12},  // R12 unmapped write
    '{1'b0, 3'd5, 4'hF, 32'h0,          32'h0,          8'd12},  // R12
    '{1'b0, 3'd3, 4'hF, 32'h0,          32'h0000_56DD,  8'd12},  // R12
    '{1'b0, 3'd0, 4'hF, 32'h0,          32'hFFFF_0000,  8'd12}   // R12
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busBe = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic [31:0] padIn = PADV;
  logic [31:0] padOut;
  logic [31:0] padOe;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busBe(busBe), .busWe(busWe), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busBe = be; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [31:0] exp, input string req);
    busAddr = a; busWe = 1'b0;
    #(CLK_P/4);
    check(req, busRdata, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R1: state while reset is held
    repeat (3) @(negedge clk);
    check("R1 padOe", padOe, 32'h0);
    check("R1 padOut", padOut, 32'h0);
    rdChk(3'd3, 32'h0, "R1 set read");
    rdChk(3'd1, 32'h0, "R1 mask read");
    rdChk(3'd2, 32'h0, "R1 pin read");
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busAddr = VECS[i].addr; busBe = VECS[i].be;
      busWdata = VECS[i].wd; busWe = VECS[i].we;
      #(CLK_P/4);
      if (!VECS[i].we)
        check($sformatf("R%0d vec%0d", VECS[i].req, i), busRdata, VECS[i].exp);
    end
    @(negedge clk);
    busWe = 1'b0;

    // R11: dir=FFFF0000, latch=000056DD -> only output pins show latch
    check("R11 padOe", padOe, 32'hFFFF_0000);
    check("R11 padOut", padOut, 32'h0);
    wr(3'd3, 4'hF, 32'hFFFF_FFFF);
    check("R11 set on inputs hidden", padOut, 32'hFFFF_0000);
    wr(3'd0, 4'hF, 32'hFFFF_FFFF);
    check("R11 all outputs", padOut, 32'hFFFF_FFFF);

    // R10: write with no strobe changes nothing
    wr(3'd4, 4'h0, 32'hFFFF_FFFF);
    rdChk(3'd3, 32'hFFFF_FFFF, "R10 no strobe");

    // R6: two-edge latency at pin read-back
    @(negedge clk);
    padIn = 32'h0000_FFFF;
    rdChk(3'd2, PADV, "R6 zero edges");
    @(negedge clk);
    rdChk(3'd2, PADV, "R6 one edge");
    @(negedge clk);
    rdChk(3'd2, 32'h0000_FFFF, "R6 two edges");

    // R1: reset in the middle of operation
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid padOe", padOe, 32'h0);
    check("R1 mid padOut", padOut, 32'h0);
    rdChk(3'd0, 32'h0, "R1 mid dir");
    rdChk(3'd3, 32'h0, "R1 mid set");
    rstN = 1'b1;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule